// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers level-sensitive interrupt requests into two eight-source local groups and drives one processor interrupt line for each group. A third eight-source byte of "mappable" requests is shared by both groups. It is filtered through two independent masks. When the first filtered result is nonzero, one fixed bit of local group 0 is pending. The second filtered result does the same for one fixed bit of local group 1. Each group also presents a registered vector that names its winning source, so an interrupt handler can go straight to the right service routine without reading any status.

All request inputs pass through a two-flop synchronizer before masking. A small register port gives access to the four masks and reads back the synchronized status. That port uses an address, a write strobe, write data and combinational read data. The cascade bit inside each local mask is kept by hardware and follows the state of its mappable mask. The block has no streaming data path, so every pin is a plain control or status signal and there is no valid/ready handshake.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset all four mask registers read 0x00, both interrupt lines are low and both vectors are 0.
- R2: A local source counts as active only when its synchronized request bit and its local mask bit are both 1. `irq_lvl0`/`irq_lvl1` is high exactly when its group has at least one active source.
- R3: The mappable byte ANDed with map mask A sets the cascade bit of group 0 (bit 2). The mappable byte ANDed with map mask B sets the cascade bit of group 1 (bit 3). A cascade bit is pending only while its filtered mappable byte is nonzero. The local request input at that bit position has no effect.
- R4: Writing a nonzero value to a map mask sets the cascade bit of the matching local mask. Writing zero to it clears that bit. A write to a local mask leaves its cascade bit unchanged.
- R5: Within a group the highest-numbered active bit wins, so bit 7 beats bit 6 and so on down to bit 0.
- R6: When a group has no active source, its vector is 0 (null) and its interrupt line is low.
- R7: Vector layout: bit 4 = valid, bit 3 = 1 when the source came through the cascade, bits 2:0 = source index. When the cascade bit is active it takes precedence over every other local source. The index then names the highest active bit of the filtered mappable byte.
- R8: Register map: 0 = local mask 0, 1 = local mask 1, 2 = map mask A, 3 = map mask B (all read/write). 4 = group 0 status, 5 = group 1 status, 6 = synchronized mappable byte (all read-only, and writes to them are ignored). Address 7 reads 0. A group status read shows the synchronized requests with the cascade bit replaced by its pending state.
- R9: A request change driven before rising edge k shows on the outputs after edge k+2. A mask write sampled at edge k shows on the outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl0_src | input | 8 | Local group 0 requests, level-sensitive |
| lvl1_src | input | 8 | Local group 1 requests, level-sensitive |
| map_src | input | 8 | Shared mappable requests, level-sensitive |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_lvl0 | output | 1 | Group 0 interrupt line |
| irq_lvl1 | output | 1 | Group 1 interrupt line |
| vec_lvl0 | output | 5 | Group 0 vector {valid, cascaded, index} |
| vec_lvl1 | output | 5 | Group 1 vector {valid, cascaded, index} |

## Verification
The assertions assume that every request input is held low while reset is asserted. That way the synchronizer's reset value matches what the pins were carrying. The checks that link a vector index back to a request bit three cycles earlier also depend on this. The stimulus keeps all sources at zero until reset is released. After that it changes sources only on falling edges and then holds them for several cycles. Register writes last exactly one cycle, so each mask change can be traced to a single sampled strobe.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_LMASK0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LMASK1  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MMASKA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MMASKB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT0   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT1   = 3'd5;
  localparam logic [ADDR_W-1:0] A_MAPSTAT = 3'd6;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned CASC0 = 2,
  parameter int unsigned CASC1 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      stat0,
  input  logic [W-1:0]      stat1,
  input  logic [W-1:0]      mapstat,
  output logic [W-1:0]      lmask0,
  output logic [W-1:0]      lmask1,
  output logic [W-1:0]      mmaska,
  output logic [W-1:0]      mmaskb,
  output logic [W-1:0]      rdata
);
  localparam logic [W-1:0] CBIT0 = W'(1) << CASC0;
  localparam logic [W-1:0] CBIT1 = W'(1) << CASC1;

  // cascade bit of each local mask is owned by the map-mask write path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lmask0 <= '0;
      lmask1 <= '0;
      mmaska <= '0;
      mmaskb <= '0;
    end else if (we) begin
      unique case (addr)
        A_LMASK0: lmask0 <= (wdata & ~CBIT0) | (lmask0 & CBIT0);
        A_LMASK1: lmask1 <= (wdata & ~CBIT1) | (lmask1 & CBIT1);
        A_MMASKA: begin
          mmaska         <= wdata;
          lmask0[CASC0]  <= |wdata;
        end
        A_MMASKB: begin
          mmaskb         <= wdata;
          lmask1[CASC1]  <= |wdata;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      A_LMASK0:  rdata = lmask0;
      A_LMASK1:  rdata = lmask1;
      A_MMASKA:  rdata = mmaska;
      A_MMASKB:  rdata = mmaskb;
      A_STAT0:   rdata = stat0;
      A_STAT1:   rdata = stat1;
      A_MAPSTAT: rdata = mapstat;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_level.sv
module irqc_level #(
  parameter int unsigned W    = 8,
  parameter int unsigned CASC = 2,
  parameter int unsigned IW   = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  loc_stat,
  input  logic [W-1:0]  map_stat,
  input  logic [W-1:0]  loc_mask,
  input  logic [W-1:0]  map_mask,
  output logic [W-1:0]  eff_stat,
  output logic          irq,
  output logic [IW+1:0] vec
);
  logic [W-1:0]  map_act;
  logic [W-1:0]  loc_act;
  logic [IW-1:0] map_idx;
  logic [IW-1:0] loc_idx;
  logic [IW+1:0] vec_d;

  always_comb begin
    map_act        = map_stat & map_mask;
    eff_stat       = loc_stat;
    eff_stat[CASC] = |map_act;
    loc_act        = eff_stat & loc_mask;
  end

  // highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    map_idx = '0;
    loc_idx = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (map_act[i]) map_idx = IW'(i);
      if (loc_act[i]) loc_idx = IW'(i);
    end
  end

  always_comb begin
    vec_d = '0;
    if (loc_act[CASC])  vec_d = {1'b1, 1'b1, map_idx};
    else if (|loc_act)  vec_d = {1'b1, 1'b0, loc_idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
      vec <= '0;
    end else begin
      irq <= |loc_act;
      vec <= vec_d;
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned CASC0 = 2,
  parameter int unsigned CASC1 = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [W-1:0]          lvl0_src,
  input  logic [W-1:0]          lvl1_src,
  input  logic [W-1:0]          map_src,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [W-1:0]          reg_wdata,
  output logic [W-1:0]          reg_rdata,
  output logic                  irq_lvl0,
  output logic                  irq_lvl1,
  output logic [$clog2(W)+1:0]  vec_lvl0,
  output logic [$clog2(W)+1:0]  vec_lvl1
);
  localparam int unsigned IW     = $clog2(W);
  localparam int unsigned NLVL   = 2;
  localparam int unsigned SYNC_W = (NLVL + 1) * W;

  logic [SYNC_W-1:0] raw_all, sync_all;
  logic [W-1:0]      map_s;
  logic [W-1:0]      loc_s    [NLVL];
  logic [W-1:0]      lmask    [NLVL];
  logic [W-1:0]      mmask    [NLVL];
  logic [W-1:0]      eff      [NLVL];
  logic              irq_g    [NLVL];
  logic [IW+1:0]     vec_g    [NLVL];

  assign raw_all = {map_src, lvl1_src, lvl0_src};

  irqc_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_all), .q(sync_all)
  );

  assign loc_s[0] = sync_all[W-1:0];
  assign loc_s[1] = sync_all[2*W-1:W];
  assign map_s    = sync_all[3*W-1:2*W];

  irqc_regs #(.W(W), .CASC0(CASC0), .CASC1(CASC1)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .stat0(eff[0]), .stat1(eff[1]), .mapstat(map_s),
    .lmask0(lmask[0]), .lmask1(lmask[1]),
    .mmaska(mmask[0]), .mmaskb(mmask[1]), .rdata(reg_rdata)
  );

  for (genvar g = 0; g < int'(NLVL); g++) begin : g_lvl
    localparam int unsigned CB = (g == 0) ? CASC0 : CASC1;
    irqc_level #(.W(W), .CASC(CB), .IW(IW)) u_lvl (
      .clk(clk), .rst_n(rst_n),
      .loc_stat(loc_s[g]), .map_stat(map_s),
      .loc_mask(lmask[g]), .map_mask(mmask[g]),
      .eff_stat(eff[g]), .irq(irq_g[g]), .vec(vec_g[g])
    );
  end

  assign irq_lvl0 = irq_g[0];
  assign irq_lvl1 = irq_g[1];
  assign vec_lvl0 = vec_g[0];
  assign vec_lvl1 = vec_g[1];
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [W-1:0]         lvl0_src,
  input logic [W-1:0]         lvl1_src,
  input logic [W-1:0]         map_src,
  input logic                 reg_we,
  input logic                 irq_lvl0,
  input logic                 irq_lvl1,
  input logic [$clog2(W)+1:0] vec_lvl0,
  input logic [$clog2(W)+1:0] vec_lvl1
);
  localparam int unsigned IW = $clog2(W);
  logic seen_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_wr <= 1'b0;
    else if (reg_we) seen_wr <= 1'b1;
  end

  // R1: with no register write since reset, nothing can be enabled
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_wr |-> (!irq_lvl0 && !irq_lvl1));

  // R6: null vector whenever the line is low, valid flag tracks the line
  assert_null_vec0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl0 == vec_lvl0[IW+1]) && (irq_lvl0 || vec_lvl0 == '0));
  assert_null_vec1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl1 == vec_lvl1[IW+1]) && (irq_lvl1 || vec_lvl1 == '0));

  // R7: a cascaded vector indexes a mappable request seen three edges back
  assert_casc_index0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_lvl0[IW] |-> |(($past(map_src, 3) >> vec_lvl0[IW-1:0]) & W'(1)));
  assert_casc_index1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_lvl1[IW] |-> |(($past(map_src, 3) >> vec_lvl1[IW-1:0]) & W'(1)));

  // R2: a local vector indexes a local request seen three edges back
  assert_local_index0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_lvl0[IW+1] && !vec_lvl0[IW]) |->
      |(($past(lvl0_src, 3) >> vec_lvl0[IW-1:0]) & W'(1)));

  // R9: no input or write activity in the latency window -> outputs hold
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_we, 1) && !$past(reg_we, 2) && !$past(reg_we, 3) &&
     $past(lvl0_src, 1) == $past(lvl0_src, 4) && $past(lvl0_src, 2) == $past(lvl0_src, 4) &&
     $past(lvl0_src, 3) == $past(lvl0_src, 4) &&
     $past(lvl1_src, 1) == $past(lvl1_src, 4) && $past(lvl1_src, 2) == $past(lvl1_src, 4) &&
     $past(lvl1_src, 3) == $past(lvl1_src, 4) &&
     $past(map_src, 1) == $past(map_src, 4) && $past(map_src, 2) == $past(map_src, 4) &&
     $past(map_src, 3) == $past(map_src, 4))
    |-> ($stable(irq_lvl0) && $stable(irq_lvl1) && $stable(vec_lvl0) && $stable(vec_lvl1)));
endmodule

bind irq_cascade_ctrl irqc_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl0_src(lvl0_src), .lvl1_src(lvl1_src),
  .map_src(map_src), .reg_we(reg_we), .irq_lvl0(irq_lvl0), .irq_lvl1(irq_lvl1),
  .vec_lvl0(vec_lvl0), .vec_lvl1(vec_lvl1)
);

// File: tb/tb_irq_cascade_ctrl.sv
module tb_irq_cascade_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lvl0_src = '0, lvl1_src = '0, map_src = '0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_lvl0, irq_lvl1;
  logic [4:0] vec_lvl0, vec_lvl1;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench-side model state
  logic [7:0] m_l0 = '0, m_l1 = '0, m_ma = '0, m_mb = '0;
  logic [7:0] s_l0 = '0, s_l1 = '0, s_map = '0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_cascade_ctrl dut (
    .clk(clk), .rst_n(rst_n), .lvl0_src(lvl0_src), .lvl1_src(lvl1_src),
    .map_src(map_src), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_lvl0(irq_lvl0), .irq_lvl1(irq_lvl1),
    .vec_lvl0(vec_lvl0), .vec_lvl1(vec_lvl1)
  );

  function automatic logic [2:0] top_bit(input logic [7:0] v);
    logic [2:0] r = 3'd0;
    for (int i = 7; i >= 0; i--) if (v[i]) begin r = 3'(i); break; end
    return r;
  endfunction

  function automatic logic [7:0] eff_of(input logic [7:0] loc, input logic [7:0] mm, input int cb);
    logic [7:0] e = loc;
    e[cb] = |(s_map & mm);
    return e;
  endfunction

  // returns {irq, vec[4:0]}
  function automatic logic [5:0] group_exp(input logic [7:0] loc, input logic [7:0] lm,
                                           input logic [7:0] mm, input int cb);
    logic [7:0] pend = s_map & mm;
    logic [7:0] act  = eff_of(loc, mm, cb) & lm;
    if (act == 0)   return 6'b0;
    if (act[cb])    return {1'b1, 1'b1, 1'b1, top_bit(pend)};
    return {1'b1, 1'b1, 1'b0, top_bit(act)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      3'd0: m_l0 = (d & ~8'h04) | (m_l0 & 8'h04);
      3'd1: m_l1 = (d & ~8'h08) | (m_l1 & 8'h08);
      3'd2: begin m_ma = d; m_l0[2] = |d; end
      3'd3: begin m_mb = d; m_l1[3] = |d; end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  // driver: apply sources, wait out the latency, push expectation
  task automatic drive(input logic [7:0] l0, input logic [7:0] l1, input logic [7:0] mp,
                       input string tag);
    logic [5:0] e0, e1;
    @(negedge clk);
    lvl0_src = l0; lvl1_src = l1; map_src = mp;
    s_l0 = l0; s_l1 = l1; s_map = mp;
    repeat (4) @(posedge clk);
    e0 = group_exp(s_l0, m_l0, m_ma, 2);
    e1 = group_exp(s_l1, m_l1, m_mb, 3);
    exp_q.push_back({e0, e1});
    tag_q.push_back(tag);
  endtask

  // monitor: compare outputs against queued expectations
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [11:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " group0"}, 32'({irq_lvl0, vec_lvl0}), 32'(e[11:6]));
      chk({t, " group1"}, 32'({irq_lvl1, vec_lvl1}), 32'(e[5:0]));
    end
  end

  task automatic drain;
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq0", 32'(irq_lvl0), 0);
    chk("R1 irq1", 32'(irq_lvl1), 0);
    chk("R1 vec0", 32'(vec_lvl0), 0);
    chk("R1 vec1", 32'(vec_lvl1), 0);
    for (int a = 0; a < 4; a++) rd(3'(a), 8'h00, "R1 mask reads zero");

    // R1/R6 everything requesting, nothing enabled
    drive(8'hFF, 8'hFF, 8'hFF, "R6 all masked off");
    drain();
    rd(3'd4, 8'hFB, "R8 status0 cascade bit not pending");
    rd(3'd6, 8'hFF, "R8 map status");

    // R2 / R5 local priority
    wr(3'd0, 8'h11);
    drive(8'h01, 8'h00, 8'h00, "R2 single local source");
    drive(8'h11, 8'h00, 8'h00, "R5 bit4 beats bit0");
    drive(8'h10, 8'h00, 8'h00, "R2 bit4 alone");
    drive(8'h0E, 8'h00, 8'h00, "R2 unmasked requests ignored");

    // R4 local write cannot set cascade bit; R3 raw cascade-position request ignored
    wr(3'd0, 8'hFF);
    drain();
    rd(3'd0, 8'hFB, "R4 cascade bit held by map mask");
    drive(8'h04, 8'h00, 8'h00, "R3 local pin at cascade position ignored");

    // R7 cascade precedence
    wr(3'd2, 8'h81);
    drain();
    rd(3'd0, 8'hFF, "R4 map mask A sets cascade bit");
    drive(8'h80, 8'h00, 8'h01, "R7 cascade beats local bit7");
    drive(8'h80, 8'h00, 8'h81, "R7 cascade index 7");
    drive(8'h80, 8'h00, 8'h02, "R3 filtered map zero not pending");

    // group 1 through map mask B
    wr(3'd1, 8'h03);
    wr(3'd3, 8'h40);
    drain();
    rd(3'd1, 8'h0B, "R4 map mask B sets cascade bit");
    drive(8'h00, 8'h03, 8'h40, "R7 group1 cascade index 6");
    drive(8'h00, 8'h80, 8'h40, "R3 group1 cascade alone");
    drive(8'h00, 8'h02, 8'h00, "R5 group1 local bit1");

    // R4 local write keeps cascade bit while map mask nonzero
    wr(3'd0, 8'h00);
    drain();
    rd(3'd0, 8'h04, "R4 local write keeps cascade bit");
    drive(8'hFF, 8'h00, 8'h01, "R7 only cascade enabled");
    wr(3'd2, 8'h00);
    drain();
    rd(3'd0, 8'h00, "R4 zero map mask clears cascade bit");

    // R8 status writes ignored, unmapped reads zero
    wr(3'd4, 8'h55);
    wr(3'd6, 8'hAA);
    rd(3'd4, eff_of(s_l0, m_ma, 2), "R8 status0 write ignored");
    rd(3'd6, s_map, "R8 map status write ignored");
    rd(3'd7, 8'h00, "R8 unmapped address");
    rd(3'd2, 8'h00, "R8 map mask A unchanged");

    // R9 latency of a mask write
    drive(8'h01, 8'h00, 8'h00, "R9 source held, mask off");
    drain();
    wr(3'd0, 8'h01);
    chk("R9 mask write not yet visible", 32'(irq_lvl0), 0);
    @(posedge clk); @(negedge clk);
    chk("R9 mask write visible next edge", 32'({irq_lvl0, vec_lvl0}), 32'(6'b110000));

    // R9 latency of a request change
    @(negedge clk);
    lvl0_src = 8'h00; s_l0 = 8'h00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 request drop after two edges", 32'(irq_lvl0), 1);
    @(posedge clk); @(negedge clk);
    chk("R9 request drop after three edges", 32'(irq_lvl0), 0);
    chk("R6 vector null after drop", 32'(vec_lvl0), 0);

    drain();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule